// File: doc/BRIEF.md
# I2C Master Clock Interval Timer with Stretch Wait

This block times every SCL half-period and every START/STOP setup or hold interval of an I2C master. A sequencer outside the block asks for a new interval by pulsing a load request. The timer then copies a 7-bit reload value into a down-counter. The counter steps down only when a phase strobe is high. That strobe comes from the core's four-phase instruction cycle on its second and fourth phases, so one instruction cycle holds two counts. When the counter reaches zero it raises a one-cycle timeout and stays at zero until it is loaded again.

The timer also handles a slave that holds the clock low. When the master's own SCL driver lets go of the line, the timer stops counting and waits. It reloads only once the synchronised SCL input is actually seen high, so a held-low clock makes the high phase start later. A suspend input freezes the count without reloading it, which lets the sequencer keep a line in a fixed state. The SCL input passes through a synchroniser whose depth is a parameter.

Top module: `i2c_baud_timer`

## Requirements
- R1: After reset, count_o is 0, tmo_o is 0 and running_o is 0.
- R2: A cycle with load_req high makes count_o equal to that cycle's reload_val on the next cycle, with running_o high.
- R3: count_o does not change across an edge where phase_tick is low and no reload is taken.
- R4: While counting, a phase_tick edge with count_o above 1, suspend low and no stretch wait lowers count_o by exactly one.
- R5: Once count_o is 0 it stays 0 until the next reload, whatever phase_tick does.
- R6: tmo_o is high for exactly one cycle, and it is the first cycle in which an interval's count is 0. running_o falls in that same cycle unless a stretch wait has begun.
- R7: A rising edge on scl_rel (0 = master drives SCL low, 1 = released) starts a stretch wait. During the wait count_o is frozen while the synchronised SCL stays low, even with phase_tick high, and running_o stays high.
- R8: During a stretch wait, the first edge where the synchronised SCL is high and scl_rel is still 1 reloads count_o from reload_val and ends the wait.
- R9: While suspend is high and no reload or wait is active, count_o is frozen.
- R10: An interval loaded with a reload value of 0 raises tmo_o on the cycle after the first counting phase_tick edge.
- R11: If scl_rel returns to 0 during a stretch wait, the wait is dropped without reloading, and counting resumes from the frozen value.
- R12: The synchronised SCL lags scl_in by SYNC_STAGES clock edges (default 2). The stretch reload therefore lands SYNC_STAGES+1 edges after scl_in rises, and count_o is unchanged before that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_val | input | RW | Interval reload value |
| load_req | input | 1 | Sequencer request to load a new interval |
| phase_tick | input | 1 | Count-enable strobe, high on the counting phases |
| suspend | input | 1 | Freeze the count without reloading |
| scl_in | input | 1 | SCL line as seen at the pin (asynchronous) |
| scl_rel | input | 1 | Master's own SCL drive state: 1 released, 0 driving low |
| count_o | output | RW | Current counter value |
| tmo_o | output | 1 | One-cycle timeout pulse |
| running_o | output | 1 | Interval in progress, including a stretch wait |

## Verification
A counter that skips or repeats a step shows on count_o on the very next phase_tick edge. It also moves tmo_o off the cycle that the reference model predicts, so a cadence fault shows up within one interval. A stretch-wait flag that is stuck set freezes count_o and keeps running_o high forever. A flag that is stuck clear lets count_o fall while SCL is held low. Either fault is visible in the first cycle after a release edge. A synchroniser of the wrong depth shifts the reload edge by a whole cycle, which the directed SCL-rise check catches exactly.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;
   localparam int unsigned BAUD_DEF_RW    = 7;
   localparam int unsigned BAUD_MAX_RW    = 16;
   localparam int unsigned BAUD_DEF_SYNC  = 2;
   localparam int unsigned BAUD_MAX_SYNC  = 4;

   typedef struct packed {
      logic tmo;
      logic active;
   } baud_flags_t;
endpackage

// File: rtl/i2c_baud_sync.sv
module i2c_baud_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_baud_arb.sv
module i2c_baud_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic load_req_i,
   input  logic scl_rel_i,
   input  logic scl_seen_i,
   output logic reload_o,
   output logic wait_o
);
   logic rel_q;
   logic wait_q;
   logic rel_rise;
   logic stretch_done;

   assign rel_rise     = scl_rel_i & ~rel_q;
   assign stretch_done = wait_q & scl_seen_i & scl_rel_i;
   assign reload_o     = load_req_i | stretch_done;
   assign wait_o       = wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q  <= 1'b1;
         wait_q <= 1'b0;
      end else begin
         rel_q <= scl_rel_i;
         if (reload_o) begin
            wait_q <= 1'b0;
         end else if (rel_rise) begin
            wait_q <= 1'b1;
         end else if (!scl_rel_i) begin
            wait_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/i2c_baud_counter.sv
module i2c_baud_counter
   import i2c_baud_pkg::*;
#(
   parameter int unsigned RW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload_i,
   input  logic [RW-1:0] reload_val_i,
   input  logic          hold_i,
   input  logic          suspend_i,
   input  logic          tick_i,
   output logic [RW-1:0] cnt_o,
   output baud_flags_t   flags_o
);
   localparam logic [RW-1:0] ONE = RW'(1);

   logic [RW-1:0] cnt_q;
   logic          tmo_q;
   logic          act_q;
   logic          step;
   logic          last;

   assign step = act_q & ~suspend_i & tick_i;
   assign last = (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmo_q <= 1'b0;
         act_q <= 1'b0;
      end else begin
         tmo_q <= 1'b0;
         if (reload_i) begin
            cnt_q <= reload_val_i;
            act_q <= 1'b1;
         end else if (hold_i) begin
            cnt_q <= cnt_q;
         end else if (step) begin
            if (last) begin
               cnt_q <= '0;
               tmo_q <= 1'b1;
               act_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign cnt_o          = cnt_q;
   assign flags_o.tmo    = tmo_q;
   assign flags_o.active = act_q;
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer
   import i2c_baud_pkg::*;
#(
   parameter int unsigned RW          = BAUD_DEF_RW,
   parameter int unsigned SYNC_STAGES = BAUD_DEF_SYNC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] reload_val,
   input  logic          load_req,
   input  logic          phase_tick,
   input  logic          suspend,
   input  logic          scl_in,
   input  logic          scl_rel,
   output logic [RW-1:0] count_o,
   output logic          tmo_o,
   output logic          running_o
);
   localparam int unsigned CW = RW;

   generate
      if (RW < 1 || RW > BAUD_MAX_RW) begin : g_bad_rw
         $error("i2c_baud_timer: RW out of range");
      end
      if (SYNC_STAGES > BAUD_MAX_SYNC) begin : g_bad_sync
         $error("i2c_baud_timer: SYNC_STAGES out of range");
      end
   endgenerate

   logic          scl_seen_w;
   logic          reload_w;
   logic          wait_w;
   logic          active_w;
   logic [CW-1:0] cnt_w;
   baud_flags_t   flags_w;

   i2c_baud_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (scl_in),
      .q_o   (scl_seen_w)
   );

   i2c_baud_arb arb_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_req_i (load_req),
      .scl_rel_i  (scl_rel),
      .scl_seen_i (scl_seen_w),
      .reload_o   (reload_w),
      .wait_o     (wait_w)
   );

   i2c_baud_counter #(.RW(CW)) cnt_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reload_i     (reload_w),
      .reload_val_i (reload_val),
      .hold_i       (wait_w),
      .suspend_i    (suspend),
      .tick_i       (phase_tick),
      .cnt_o        (cnt_w),
      .flags_o      (flags_w)
   );

   assign active_w  = flags_w.active;
   assign count_o   = cnt_w;
   assign tmo_o     = flags_w.tmo;
   assign running_o = active_w | wait_w;
endmodule

// File: rtl/i2c_baud_timer_chk.sv
module i2c_baud_timer_chk #(
   parameter int unsigned RW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [RW-1:0] reload_val,
   input logic          load_req,
   input logic          phase_tick,
   input logic          suspend,
   input logic          scl_rel,
   input logic [RW-1:0] count_o,
   input logic          tmo_o,
   input logic          running_o,
   input logic          reload_w,
   input logic          wait_w,
   input logic          active_w,
   input logic          scl_seen_w
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (count_o == '0 && !tmo_o && !running_o));

   // R2
   load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |=> (count_o == $past(reload_val) && running_o));

   // R3
   no_tick_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_w && !phase_tick) |=> $stable(count_o));

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_w && !wait_w && !suspend && phase_tick && active_w && count_o > RW'(1))
      |=> (count_o == RW'($past(count_o) - RW'(1))));

   // R5
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0 && !reload_w) |=> (count_o == '0));

   // R6
   tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |=> !tmo_o);

   // R6
   tmo_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |-> (count_o == '0));

   // R7
   stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_w && !reload_w) |=> $stable(count_o));

   // R8
   stretch_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_w && scl_seen_w && scl_rel) |=> (count_o == $past(reload_val) && running_o && !wait_w));

   // R9
   suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend && !reload_w && !wait_w) |=> $stable(count_o));

   // R10
   zero_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_w && count_o == '0 && phase_tick && !suspend && !reload_w && !wait_w) |=> tmo_o);

   // R11
   wait_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_w && !scl_rel && !load_req) |=> !wait_w);
endmodule

bind i2c_baud_timer i2c_baud_timer_chk #(.RW(RW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reload_val (reload_val),
   .load_req   (load_req),
   .phase_tick (phase_tick),
   .suspend    (suspend),
   .scl_rel    (scl_rel),
   .count_o    (count_o),
   .tmo_o      (tmo_o),
   .running_o  (running_o),
   .reload_w   (reload_w),
   .wait_w     (wait_w),
   .active_w   (active_w),
   .scl_seen_w (scl_seen_w)
);

// File: tb/i2c_baud_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_baud_timer_tb_top;
   localparam int RW   = 7;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [RW-1:0] reload_val;
   logic          load_req;
   logic          phase_tick;
   logic          suspend;
   logic          scl_in;
   logic          scl_rel;
   logic [RW-1:0] count_o;
   logic          tmo_o;
   logic          running_o;

   int nchk  = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   i2c_baud_timer #(.RW(RW), .SYNC_STAGES(SYNC)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (reload_val),
      .load_req   (load_req),
      .phase_tick (phase_tick),
      .suspend    (suspend),
      .scl_in     (scl_in),
      .scl_rel    (scl_rel),
      .count_o    (count_o),
      .tmo_o      (tmo_o),
      .running_o  (running_o)
   );

   // Reference model built from the requirements
   logic [SYNC:0]   m_pipe;
   logic            m_rel_q;
   logic            m_wait;
   logic [RW-1:0]   m_cnt;
   logic            m_tmo;
   logic            m_act;

   function automatic logic m_seen(input logic [SYNC:0] p, input logic d);
      return (SYNC == 0) ? d : p[SYNC];
   endfunction

   function automatic logic [RW-1:0] m_next_cnt(input logic [RW-1:0] c);
      return (c <= 1) ? '0 : c - 1'b1;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic seen;
      logic rl;
      if (!rst_n) begin
         m_pipe  <= '0;
         m_rel_q <= 1'b1;
         m_wait  <= 1'b0;
         m_cnt   <= '0;
         m_tmo   <= 1'b0;
         m_act   <= 1'b0;
      end else begin
         seen = m_seen(m_pipe, scl_in);
         rl   = load_req | (m_wait & seen & scl_rel);
         for (int i = SYNC; i >= 1; i--) m_pipe[i] <= (i == 1) ? scl_in : m_pipe[i-1];
         m_rel_q <= scl_rel;
         if (rl) m_wait <= 1'b0;
         else if (scl_rel && !m_rel_q) m_wait <= 1'b1;
         else if (!scl_rel) m_wait <= 1'b0;
         m_tmo <= 1'b0;
         if (rl) begin
            m_cnt <= reload_val;
            m_act <= 1'b1;
         end else if (m_wait) begin
            m_cnt <= m_cnt;
         end else if (m_act && !suspend && phase_tick) begin
            m_cnt <= m_next_cnt(m_cnt);
            if (m_cnt <= 1) begin
               m_tmo <= 1'b1;
               m_act <= 1'b0;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = int'($urandom(32'h2C0F_FEE5));
      rst_n = 1'b0; reload_val = '0; load_req = 0; phase_tick = 0;
      suspend = 0; scl_in = 0; scl_rel = 0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      check("R1 count", int'(count_o), 0);
      check("R1 tmo", int'(tmo_o), 0);
      check("R1 running", int'(running_o), 0);

      // Load and count down with a tick on every cycle
      reload_val = 7'd5; load_req = 1; cyc(); load_req = 0;
      check("R2 count", int'(count_o), 5);
      check("R2 running", int'(running_o), 1);
      repeat (3) begin cyc(); check("R3 no tick", int'(count_o), 5); end
      phase_tick = 1;
      for (int k = 1; k <= 5; k++) begin
         cyc();
         check("R4 step", int'(count_o), 5 - k);
         check("R6 tmo", int'(tmo_o), (k == 5) ? 1 : 0);
      end
      check("R6 running", int'(running_o), 0);
      cyc();
      check("R6 pulse width", int'(tmo_o), 0);
      repeat (3) begin cyc(); check("R5 hold zero", int'(count_o), 0); end

      // Zero reload
      phase_tick = 0; reload_val = 7'd0; load_req = 1; cyc(); load_req = 0;
      check("R10 loaded", int'(running_o), 1);
      check("R10 no early tmo", int'(tmo_o), 0);
      phase_tick = 1; cyc();
      check("R10 tmo", int'(tmo_o), 1);
      check("R10 running", int'(running_o), 0);

      // Suspend freezes
      phase_tick = 0; reload_val = 7'd6; load_req = 1; cyc(); load_req = 0;
      phase_tick = 1; suspend = 1;
      repeat (4) begin cyc(); check("R9 frozen", int'(count_o), 6); end
      suspend = 0; cyc();
      check("R9 resumes", int'(count_o), 5);
      phase_tick = 0;

      // Stretch: release with SCL held low
      scl_rel = 1; cyc();
      check("R7 running", int'(running_o), 1);
      reload_val = 7'd9; phase_tick = 1;
      repeat (6) begin cyc(); check("R7 stretch", int'(count_o), 5); end
      phase_tick = 0; scl_in = 1;
      repeat (SYNC) begin cyc(); check("R12 latency", int'(count_o), 5); end
      cyc();
      check("R8 reload", int'(count_o), 9);
      check("R8 running", int'(running_o), 1);

      // Wait dropped when master drives low again
      scl_rel = 0; scl_in = 0; reload_val = 7'd7; load_req = 1; cyc(); load_req = 0;
      check("R2 reload", int'(count_o), 7);
      scl_rel = 1; cyc();
      phase_tick = 1; cyc();
      check("R7 frozen", int'(count_o), 7);
      scl_rel = 0; cyc();
      check("R11 drop", int'(count_o), 7);
      cyc();
      check("R11 resume", int'(count_o), 6);
      phase_tick = 0;

      // Constrained random against the model
      for (int n = 0; n < 4000; n++) begin
         cyc();
         check("R4 rand count", int'(count_o), int'(m_cnt));
         check("R6 rand tmo", int'(tmo_o), int'(m_tmo));
         check("R7 rand running", int'(running_o), int'(m_act | m_wait));
         if (($urandom % 100) < 85) phase_tick = n[0];
         else phase_tick = 1'($urandom);
         load_req = (($urandom % 40) == 0);
         if (($urandom % 16) == 0) scl_rel = ~scl_rel;
         if (!scl_rel) scl_in = 0;
         else if (($urandom % 6) == 0) scl_in = 1;
         if (($urandom % 20) == 0) suspend = ~suspend;
         if (($urandom % 8) == 0) reload_val = RW'($urandom);
         else reload_val = RW'($urandom % 12);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule